// File: doc/BRIEF.md
# Low-power mode sequencing controller

This block sequences the power states of a small microcontroller core. Software writes a two-bit power-control register: bit 0 requests idle and bit 1 requests power-down. The block enters the requested mode at the next instruction boundary. In idle, only the CPU clock is stopped. In power-down, the oscillator and every clock are stopped. Whenever the core is not running, the bus strobes and the port latches are held at their current values.

Idle ends when an enabled interrupt becomes pending. Power-down ends in two phases through an enabled, active-low wake pin. Pulling the pin low restarts the oscillator. Releasing the pin completes the exit, but only after an oscillator-stabilisation counter has run out. When several wake pins are low, the first one released ends power-down, and the block records which pin that was. A reset pin can end any mode. It takes effect only after being held for a fixed number of oscillator cycles.

The sequencer runs on the raw oscillator clock. In power-down it treats that clock as an always-on reference and uses it only to watch the pins, to count the stabilisation time and to filter the reset pin.

Top module: `lpm_seq`

## Requirements
- R1: After rst_ni is released, pcon_o = 2'b00, osc_en_o = 1, hold_o = 0, wake_src_o = 0, and both cpu_clk_o and per_clk_o follow clk_i.
- R2: A write with pcon_wdata_i[0] = 1 sets pcon_o[0]. The block enters idle on the first later clock edge at which insn_done_i = 1, and not before. In idle, hold_o = 1, osc_en_o = 1, cpu_clk_o stays low and per_clk_o keeps toggling.
- R3: In idle, a non-zero (irq_pend_i & irq_en_i) returns the block to run on the next edge, with pcon_o cleared and hold_o = 0. A pending interrupt whose enable bit is 0 has no effect.
- R4: A write with pcon_wdata_i[1] = 1 enters power-down at the next instruction boundary. In power-down, osc_en_o = 0, hold_o = 1, and cpu_clk_o and per_clk_o both stay low.
- R5: If both power-control bits are 1, power-down is entered and idle is not.
- R6: In power-down, a low level on a wake pin whose wake_en_i bit is 1 sets osc_en_o on the next edge, while the clocks stay off. A low level on a disabled pin leaves osc_en_o at 0.
- R7: The exit from power-down completes on the edge after both of these hold: STAB_CYC cycles have passed since the oscillator restarted, and a pin that was seen low is high. A pin released earlier does not shorten this wait. On exit, pcon_o is cleared.
- R8: While the wake pins are held low, power-down does not end. When more than one pin was low, the first one released ends power-down. wake_src_o then holds a one-hot code in which bit i means pin i. If several pins are released on the same edge, the lowest index wins.
- R9: The reset pin takes effect only after RST_HOLD consecutive high cycles. A shorter pulse is ignored. Once the reset takes effect, the block returns to run with pcon_o and wake_src_o cleared. In power-down, a high reset pin also sets osc_en_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rst_pin_i | input | 1 | External reset pin, active high, filtered by hold time |
| pcon_we_i | input | 1 | Power-control register write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| irq_pend_i | input | IRQ_N | Interrupt pending vector |
| irq_en_i | input | IRQ_N | Interrupt enable vector |
| wake_ni | input | WAKE_N | Active-low external wake pins |
| wake_en_i | input | WAKE_N | Wake pin enables |
| pcon_o | output | 2 | Power-control register read-back |
| cpu_clk_o | output | 1 | Gated CPU clock |
| per_clk_o | output | 1 | Gated peripheral clock |
| osc_en_o | output | 1 | Oscillator enable |
| hold_o | output | 1 | Hold bus strobes high and freeze port latches |
| wake_src_o | output | WAKE_N | One-hot pin that completed the last power-down exit |

## Verification
A wrong state register shows up at hold_o and osc_en_o on the edge after the stimulus, because both outputs decode the state directly. Gated clocks lag by half a cycle, so an enable fault appears on the high phase after that edge. The stabilisation and reset-hold counters are probed at their exact boundary cycles, so an off-by-one in either one moves the exit or the reset by one edge. A wrong release mask shows up as a wrong wake_src_o code or as an exit while the pin is still held low.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2,
    ST_WARM = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_rst_filter.sv
module lpm_rst_filter #(
  parameter int unsigned HOLD = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!pin_i)               cnt_q <= '0;
    else if (cnt_q != CW'(HOLD))   cnt_q <= cnt_q + 1'b1;
  end

  assign rst_o = (cnt_q == CW'(HOLD));

  AST_RST_NEEDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> $past(pin_i)); // R9
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int unsigned N    = 2,
  parameter int unsigned STAB = 1024
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pd_i,
  input  logic         warm_i,
  input  logic [N-1:0] pin_ni,
  input  logic [N-1:0] en_i,
  output logic         restart_o,
  output logic         stab_done_o,
  output logic         done_o,
  output logic [N-1:0] src_o
);
  localparam int unsigned CW = $clog2(STAB + 1);

  logic [CW-1:0] cnt_q;
  logic [N-1:0]  armed_q, low, rel;

  assign low = en_i & ~pin_ni;

  // pins seen low since power-down began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               armed_q <= '0;
    else if (pd_i || warm_i)   armed_q <= armed_q | low;
    else                       armed_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!warm_i)                     cnt_q <= '0;
    else if (cnt_q != CW'(STAB))          cnt_q <= cnt_q + 1'b1;
  end

  assign stab_done_o = (cnt_q == CW'(STAB));
  assign restart_o   = pd_i && (|low);
  assign rel         = armed_q & pin_ni;
  assign src_o       = rel & (~rel + 1'b1);
  assign done_o      = warm_i && stab_done_o && (|rel);

  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_o)); // R8
  AST_NO_EXIT_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((src_o & pin_ni) != '0)); // R8
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable sampled on the low phase, so the gated clock never glitches
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned IRQ_N    = 8,
  parameter int unsigned WAKE_N   = 2,
  parameter int unsigned STAB_CYC = 1024,
  parameter int unsigned RST_HOLD = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              pcon_we_i,
  input  logic [1:0]        pcon_wdata_i,
  input  logic              insn_done_i,
  input  logic [IRQ_N-1:0]  irq_pend_i,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic [WAKE_N-1:0] wake_ni,
  input  logic [WAKE_N-1:0] wake_en_i,
  output logic [1:0]        pcon_o,
  output logic              cpu_clk_o,
  output logic              per_clk_o,
  output logic              osc_en_o,
  output logic              hold_o,
  output logic [WAKE_N-1:0] wake_src_o
);
  lpm_state_e        st_q, st_d;
  logic [1:0]        pcon_q, pcon_d;
  logic [WAKE_N-1:0] src_q, src_d, src;
  logic              sys_rst, restart, stab_done, wake_done;
  logic              cpu_run, per_run;

  lpm_rst_filter #(.HOLD(RST_HOLD)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (rst_pin_i),
    .rst_o (sys_rst)
  );

  lpm_wake #(.N(WAKE_N), .STAB(STAB_CYC)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (st_q == ST_PD),
    .warm_i     (st_q == ST_WARM),
    .pin_ni     (wake_ni),
    .en_i       (wake_en_i),
    .restart_o  (restart),
    .stab_done_o(stab_done),
    .done_o     (wake_done),
    .src_o      (src)
  );

  always_comb begin
    st_d   = st_q;
    pcon_d = pcon_q;
    src_d  = src_q;
    if (st_q == ST_RUN && pcon_we_i) pcon_d = pcon_wdata_i;
    unique case (st_q)
      ST_RUN: begin
        if (insn_done_i && pcon_q[1]) begin
          st_d  = ST_PD;  // power-down wins over idle
          src_d = '0;
        end else if (insn_done_i && pcon_q[0]) begin
          st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (|(irq_pend_i & irq_en_i)) begin
          st_d   = ST_RUN;
          pcon_d = '0;
        end
      end
      ST_PD: begin
        if (restart) st_d = ST_WARM;
      end
      ST_WARM: begin
        if (wake_done) begin
          st_d   = ST_RUN;
          pcon_d = '0;
          src_d  = src;
        end
      end
      default: st_d = ST_RUN;
    endcase
    if (sys_rst) begin
      st_d   = ST_RUN;
      pcon_d = '0;
      src_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      pcon_q <= '0;
      src_q  <= '0;
    end else begin
      st_q   <= st_d;
      pcon_q <= pcon_d;
      src_q  <= src_d;
    end
  end

  assign cpu_run = (st_q == ST_RUN) || sys_rst;
  assign per_run = (st_q == ST_RUN) || (st_q == ST_IDLE) || sys_rst;

  lpm_clk_gate u_cpu_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cpu_run),
    .clk_o (cpu_clk_o)
  );

  lpm_clk_gate u_per_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (per_run),
    .clk_o (per_clk_o)
  );

  assign pcon_o     = pcon_q;
  assign osc_en_o   = (st_q != ST_PD) || rst_pin_i;
  assign hold_o     = (st_q != ST_RUN) && !sys_rst;
  assign wake_src_o = src_q;

  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN && $past(st_q) == ST_RUN) |-> $past(insn_done_i)); // R2
  AST_PD_PRECEDENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_RUN) |-> !$past(pcon_q[1])); // R5
  AST_EXIT_AFTER_STAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_WARM && !$past(sys_rst)) |-> $past(stab_done)); // R7
  AST_IDLE_WAKE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_IDLE && !$past(sys_rst))
      |-> $past((irq_pend_i & irq_en_i) != '0)); // R3
endmodule

// File: tb/lpm_seq_tb_top.sv
`timescale 1ns/1ps
module lpm_seq_tb_top;
  localparam int unsigned IRQ_N = 8, WAKE_N = 2, STAB = 8, RHOLD = 24;

  logic              clk = 1'b0, rst_ni = 1'b0, rst_pin = 1'b0;
  logic              pcon_we = 1'b0, insn_done = 1'b0;
  logic [1:0]        pcon_wdata = '0;
  logic [IRQ_N-1:0]  irq_pend = '0, irq_en = '0;
  logic [WAKE_N-1:0] wake_n = '1, wake_en = '0;
  logic [1:0]        pcon;
  logic              cpu_clk, per_clk, osc_en, hold;
  logic [WAKE_N-1:0] wake_src;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lpm_seq #(.IRQ_N(IRQ_N), .WAKE_N(WAKE_N), .STAB_CYC(STAB), .RST_HOLD(RHOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_i(rst_pin), .pcon_we_i(pcon_we),
    .pcon_wdata_i(pcon_wdata), .insn_done_i(insn_done), .irq_pend_i(irq_pend),
    .irq_en_i(irq_en), .wake_ni(wake_n), .wake_en_i(wake_en), .pcon_o(pcon),
    .cpu_clk_o(cpu_clk), .per_clk_o(per_clk), .osc_en_o(osc_en), .hold_o(hold),
    .wake_src_o(wake_src)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_pcon(logic [1:0] v);
    pcon_we = 1'b1; pcon_wdata = v;
    tick();
    pcon_we = 1'b0;
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pcon", pcon, 0);
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "hold", hold, 0);
    chk("R1", "wake_src", wake_src, 0);
    chk("R1", "cpu_clk", cpu_clk, 1);
    chk("R1", "per_clk", per_clk, 1);
  endtask

  task automatic t_idle();
    write_pcon(2'b01);
    chk("R2", "pcon after write", pcon, 1);
    tick(2);
    chk("R2", "no entry before boundary", hold, 0);
    boundary();
    chk("R2", "hold in idle", hold, 1);
    tick();
    chk("R2", "cpu_clk gated", cpu_clk, 0);
    chk("R2", "per_clk running", per_clk, 1);
    chk("R2", "osc_en", osc_en, 1);
    irq_pend = 8'h04; irq_en = 8'h01;
    tick(2);
    chk("R3", "disabled irq ignored", hold, 1);
    chk("R3", "pcon kept", pcon, 1);
    irq_en = 8'h05;
    tick();
    chk("R3", "wake to run", hold, 0);
    chk("R3", "pcon cleared", pcon, 0);
    irq_pend = '0; irq_en = '0;
    tick();
    chk("R3", "cpu_clk resumed", cpu_clk, 1);
  endtask

  task automatic t_pd_single();
    write_pcon(2'b10);
    boundary();
    chk("R4", "hold", hold, 1);
    chk("R4", "osc_en off", osc_en, 0);
    tick();
    chk("R4", "cpu_clk off", cpu_clk, 0);
    chk("R4", "per_clk off", per_clk, 0);
    wake_en = 2'b01; wake_n = 2'b01;
    tick(2);
    chk("R6", "disabled pin ignored", osc_en, 0);
    wake_n = 2'b10;
    tick();
    chk("R6", "osc restarted", osc_en, 1);
    chk("R6", "still held", hold, 1);
    wake_n = 2'b11;
    tick(STAB);
    chk("R7", "early release waits", hold, 1);
    chk("R6", "per_clk off while warming", per_clk, 0);
    tick();
    chk("R7", "exit after stab", hold, 0);
    chk("R7", "pcon cleared", pcon, 0);
    chk("R8", "wake_src pin0", wake_src, 1);
    wake_en = '0;
  endtask

  task automatic t_pd_both();
    write_pcon(2'b11);
    boundary();
    tick();
    chk("R5", "per_clk off (power-down)", per_clk, 0);
    chk("R5", "osc_en off", osc_en, 0);
    wake_en = 2'b11; wake_n = 2'b00;
    tick();
    chk("R6", "osc restart", osc_en, 1);
    tick(STAB + 3);
    chk("R8", "held pins keep pd", hold, 1);
    wake_n = 2'b10;
    tick();
    chk("R8", "first release exits", hold, 0);
    chk("R8", "wake_src pin1", wake_src, 2);
    wake_n = 2'b11; wake_en = '0;
    tick();
  endtask

  task automatic t_rst_idle();
    write_pcon(2'b01);
    boundary();
    rst_pin = 1'b1;
    tick(RHOLD - 1);
    rst_pin = 1'b0;
    tick();
    chk("R9", "short pulse ignored", hold, 1);
    chk("R9", "pcon kept", pcon, 1);
    rst_pin = 1'b1;
    tick(RHOLD);
    chk("R9", "reset effective hold", hold, 0);
    tick();
    chk("R9", "pcon cleared", pcon, 0);
    rst_pin = 1'b0;
    tick(2);
    chk("R9", "run after reset", hold, 0);
  endtask

  task automatic t_rst_pd();
    write_pcon(2'b10);
    boundary();
    chk("R9", "pd entered", osc_en, 0);
    rst_pin = 1'b1;
    #0.5;
    chk("R9", "osc on with reset pin", osc_en, 1);
    tick(RHOLD + 1);
    chk("R9", "pd ended", hold, 0);
    chk("R9", "pcon cleared", pcon, 0);
    chk("R9", "wake_src cleared", wake_src, 0);
    rst_pin = 1'b0;
    tick();
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_idle();
    t_pd_single();
    t_pd_both();
    t_rst_idle();
    t_rst_pd();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule